// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers interrupt requests from thirteen peripheral sources, numbered 1 to 13, and presents one interrupt toward a CPU. Each source has a pending bit and a mask bit. Each source also has an 8-bit control byte and an 8-bit vector byte. A source is a candidate when it is pending and not masked. Among the candidates, the block picks the one whose 5-bit priority field (control bits [4:0]) is strictly the largest. When two candidates have equal priority, the lower source number wins.

The winner's control bits [4:2] give the 3-bit interrupt level. If control bit 7 of the winner is set, the block requests an autovector, and the vector number is 24 plus the level. If bit 7 is clear, the winner's own vector byte is presented.

Software reaches the registers over a simple bus with byte and 16-bit word accesses in big-endian lane order. The interrupt outputs are decoded straight from the stored registers. A register write or a change in requests therefore shows at the outputs one clock after it is captured.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A source takes part in arbitration only when its pending bit is 1 and its mask bit is 0. Mask bit n (1 = blocked) belongs to source n.
- R2: The winner is the active source with the strictly largest control bits [4:0]. Among equal values the lowest source number wins. The winner's number appears on `irq_src_o`.
- R3: `irq_level_o` equals bits [4:2] of the winning source's control byte.
- R4: When no source is active, or when the winner's level is 0, the outputs `irq_level_o`, `irq_vec_o`, `irq_src_o` and `irq_auto_o` are all 0.
- R5: When the winner's control bit 7 is 1, `irq_auto_o` is 1 and `irq_vec_o` equals 24 plus the level.
- R6: When the winner's control bit 7 is 0, `irq_auto_o` is 0 and `irq_vec_o` equals that source's vector byte.
- R7: Pending bit n follows `src_req_i[n]` one clock later and clears when the request drops. Pending bits 0, 14 and 15 read 0. Writes to the pending address have no effect.
- R8: After reset the mask word reads 0xFFFF. The pending word, every control byte and every vector byte read 0.
- R9: A write to a control byte, a vector byte or the mask takes effect on the interrupt outputs in the first cycle after the clock edge that captures it.
- R10: The register map is as follows.
  - The control byte of source n is at byte address 0x13+n (0x14 to 0x20).
  - The vector byte of source n is at 0x80+n.
  - The mask word is at 0x36 and the pending word is at 0x3A.
  - A word access ignores address bit 0. It carries byte A (even) in data [15:8] and byte A+1 in [7:0].
  - A byte access uses data [7:0], and a byte read returns 0 in [15:8].
- R11: Reads of unmapped addresses return 0, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 13 ([13:1]) | Request level from each peripheral source |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr_i | input | 9 | Byte address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the cycle the read is presented |
| irq_level_o | output | 3 | Requested interrupt level, 0 = none |
| irq_vec_o | output | 8 | Vector number for the current request |
| irq_auto_o | output | 1 | Autovector request |
| irq_src_o | output | 4 | Winning source number, 0 = none |

## Verification
The assertions assume that the request inputs and the bus controls are stable at each rising edge. They also assume that a bus access lasts a single cycle, with `bus_sel_i` dropped before the next one.

The stimulus drives every input on the falling edge. Each write is held for exactly one rising edge, and reads carry no write strobe. Requests may change on any cycle, because pending capture has no handshake.

Tie cases, level-zero winners and the autovector path are set up on purpose. A random phase then mixes byte and word writes across the map, including the pending and unmapped addresses, while the request lines keep changing.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int ADDR_W    = 9;
    localparam int DATA_W    = 16;
    localparam int PRIO_W    = 5;
    localparam int LVL_W     = 3;
    localparam int CTRL_BASE = 'h13;   // control byte of source n at CTRL_BASE + n
    localparam int VEC_BASE  = 'h80;   // vector byte of source n at VEC_BASE + n
    localparam int MASK_ADDR = 'h36;
    localparam int PEND_ADDR = 'h3A;
    localparam int AUTO_BASE = 24;
    localparam logic [15:0] MASK_RESET = 16'hFFFF;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 13
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC:1]                src_req_i,
    input  logic                            bus_sel_i,
    input  logic                            bus_wr_i,
    input  logic                            bus_word_i,
    input  logic [ADDR_W-1:0]               bus_addr_i,
    input  logic [DATA_W-1:0]               bus_wdata_i,
    output logic [DATA_W-1:0]               bus_rdata_o,
    output logic [15:0]                     mask_o,
    output logic [15:0]                     pend_o,
    output logic [NUM_SRC:1][PRIO_W-1:0]    prio_o,
    output logic [NUM_SRC:1]                auto_o,
    output logic [NUM_SRC:1][7:0]           vec_o
);
    typedef struct packed {
        logic [15:0]            mask;
        logic [15:0]            pend;
        logic [NUM_SRC:1][7:0]  ctrl;
        logic [NUM_SRC:1][7:0]  vec;
    } st_t;

    st_t st_d, st_q;

    logic [ADDR_W-1:0] addr_even, addr_odd;
    assign addr_even = {bus_addr_i[ADDR_W-1:1], 1'b0};
    assign addr_odd  = {bus_addr_i[ADDR_W-1:1], 1'b1};

    function automatic st_t put_byte(st_t s, logic [ADDR_W-1:0] a, logic [7:0] d);
        st_t r;
        r = s;
        for (int n = 1; n <= NUM_SRC; n++) begin
            if (int'(a) == CTRL_BASE + n) r.ctrl[n] = d;
            if (int'(a) == VEC_BASE + n)  r.vec[n]  = d;
        end
        if (int'(a) == MASK_ADDR)     r.mask[15:8] = d;
        if (int'(a) == MASK_ADDR + 1) r.mask[7:0]  = d;
        return r;
    endfunction

    function automatic logic [7:0] get_byte(st_t s, logic [ADDR_W-1:0] a);
        logic [7:0] r;
        r = 8'h00;
        for (int n = 1; n <= NUM_SRC; n++) begin
            if (int'(a) == CTRL_BASE + n) r = s.ctrl[n];
            if (int'(a) == VEC_BASE + n)  r = s.vec[n];
        end
        if (int'(a) == MASK_ADDR)     r = s.mask[15:8];
        if (int'(a) == MASK_ADDR + 1) r = s.mask[7:0];
        if (int'(a) == PEND_ADDR)     r = s.pend[15:8];
        if (int'(a) == PEND_ADDR + 1) r = s.pend[7:0];
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        st_d.pend = '0;
        st_d.pend[NUM_SRC:1] = src_req_i;
        if (bus_sel_i && bus_wr_i) begin
            if (bus_word_i) begin
                st_d = put_byte(st_d, addr_even, bus_wdata_i[15:8]);
                st_d = put_byte(st_d, addr_odd,  bus_wdata_i[7:0]);
            end else begin
                st_d = put_byte(st_d, bus_addr_i, bus_wdata_i[7:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= MASK_RESET;
            st_q.pend <= '0;
            st_q.ctrl <= '0;
            st_q.vec  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i && !bus_wr_i) begin
            if (bus_word_i) bus_rdata_o = {get_byte(st_q, addr_even), get_byte(st_q, addr_odd)};
            else            bus_rdata_o = {8'h00, get_byte(st_q, bus_addr_i)};
        end
    end

    assign mask_o = st_q.mask;
    assign pend_o = st_q.pend;
    assign vec_o  = st_q.vec;

    for (genvar n = 1; n <= NUM_SRC; n++) begin : g_fields
        assign prio_o[n] = st_q.ctrl[n][PRIO_W-1:0];
        assign auto_o[n] = st_q.ctrl[n][7];
    end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int SRC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC:1]                active_i,
    input  logic [NUM_SRC:1][PRIO_W-1:0]    prio_i,
    output logic [SRC_W-1:0]                win_o
);
    logic [PRIO_W-1:0] best;

    // Linear scan from source 1 upward; strict compare keeps the lower number on ties.
    always_comb begin
        best  = '0;
        win_o = '0;
        for (int n = 1; n <= NUM_SRC; n++) begin
            if (active_i[n] && (prio_i[n] > best)) begin
                best  = prio_i[n];
                win_o = SRC_W'(n);
            end
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int SRC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [SRC_W-1:0]                win_i,
    input  logic [NUM_SRC:1][LVL_W-1:0]     lvl_i,
    input  logic [NUM_SRC:1]                auto_i,
    input  logic [NUM_SRC:1][7:0]           vec_i,
    output logic [LVL_W-1:0]                level_o,
    output logic [7:0]                      vec_o,
    output logic                            auto_o,
    output logic [SRC_W-1:0]                src_o
);
    logic [LVL_W-1:0] sel_lvl;
    logic             sel_auto;
    logic [7:0]       sel_vec;

    always_comb begin
        sel_lvl  = '0;
        sel_auto = 1'b0;
        sel_vec  = '0;
        for (int n = 1; n <= NUM_SRC; n++) begin
            if (int'(win_i) == n) begin
                sel_lvl  = lvl_i[n];
                sel_auto = auto_i[n];
                sel_vec  = vec_i[n];
            end
        end
    end

    always_comb begin
        level_o = '0;
        vec_o   = '0;
        auto_o  = 1'b0;
        src_o   = '0;
        if (sel_lvl != '0) begin
            level_o = sel_lvl;
            auto_o  = sel_auto;
            src_o   = win_i;
            vec_o   = sel_auto ? (8'(AUTO_BASE) + {5'b0, sel_lvl}) : sel_vec;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int SRC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC:1]    src_req_i,
    input  logic                bus_sel_i,
    input  logic                bus_wr_i,
    input  logic                bus_word_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic [LVL_W-1:0]    irq_level_o,
    output logic [7:0]          irq_vec_o,
    output logic                irq_auto_o,
    output logic [SRC_W-1:0]    irq_src_o
);
    logic [15:0]                    mask_w, pend_w;
    logic [NUM_SRC:1][PRIO_W-1:0]   prio_w;
    logic [NUM_SRC:1][LVL_W-1:0]    lvl_w;
    logic [NUM_SRC:1]               auto_w;
    logic [NUM_SRC:1][7:0]          vec_w;
    logic [NUM_SRC:1]               active_w;
    logic [SRC_W-1:0]               win_w;

    irq_prio_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_req_i   (src_req_i),
        .bus_sel_i   (bus_sel_i),
        .bus_wr_i    (bus_wr_i),
        .bus_word_i  (bus_word_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .mask_o      (mask_w),
        .pend_o      (pend_w),
        .prio_o      (prio_w),
        .auto_o      (auto_w),
        .vec_o       (vec_w)
    );

    assign active_w = pend_w[NUM_SRC:1] & ~mask_w[NUM_SRC:1];

    for (genvar n = 1; n <= NUM_SRC; n++) begin : g_lvl
        assign lvl_w[n] = prio_w[n][PRIO_W-1:PRIO_W-LVL_W];
    end

    irq_prio_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
        .active_i (active_w),
        .prio_i   (prio_w),
        .win_o    (win_w)
    );

    irq_prio_enc #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_enc (
        .win_i   (win_w),
        .lvl_i   (lvl_w),
        .auto_i  (auto_w),
        .vec_i   (vec_w),
        .level_o (irq_level_o),
        .vec_o   (irq_vec_o),
        .auto_o  (irq_auto_o),
        .src_o   (irq_src_o)
    );
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int SRC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC:1]                src_req,
    input  logic [15:0]                     mask,
    input  logic [15:0]                     pend,
    input  logic [NUM_SRC:1][LVL_W-1:0]     lvl,
    input  logic [NUM_SRC:1]                auto_bit,
    input  logic [NUM_SRC:1][7:0]           vec,
    input  logic [LVL_W-1:0]                irq_level,
    input  logic [7:0]                      irq_vec,
    input  logic                            irq_auto,
    input  logic [SRC_W-1:0]                irq_src
);
    logic [LVL_W-1:0] win_lvl;
    logic             win_auto;
    logic [7:0]       win_vec;

    always_comb begin
        win_lvl  = '0;
        win_auto = 1'b0;
        win_vec  = '0;
        for (int n = 1; n <= NUM_SRC; n++) begin
            if (int'(irq_src) == n) begin
                win_lvl  = lvl[n];
                win_auto = auto_bit[n];
                win_vec  = vec[n];
            end
        end
    end

    a_r1_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src != '0) |-> (pend[irq_src] && !mask[irq_src]));

    a_r3_level_field: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (irq_src != '0 && irq_level == win_lvl));

    a_r4_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) |-> (irq_vec == 8'h00 && irq_src == '0 && !irq_auto));

    a_r5_autovector: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0 && win_auto) |-> (irq_auto && irq_vec == 8'(AUTO_BASE) + {5'b0, irq_level}));

    a_r6_vector_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0 && !win_auto) |-> (!irq_auto && irq_vec == win_vec));

    a_r7_pend_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend[NUM_SRC:1] == $past(src_req)));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req_i),
    .mask      (mask_w),
    .pend      (pend_w),
    .lvl       (lvl_w),
    .auto_bit  (auto_w),
    .vec       (vec_w),
    .irq_level (irq_level_o),
    .irq_vec   (irq_vec_o),
    .irq_auto  (irq_auto_o),
    .irq_src   (irq_src_o)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:1] req = '0;
    logic        sel = 1'b0, wr = 1'b0, word = 1'b0;
    logic [8:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [2:0]  level;
    logic [7:0]  vec;
    logic        autov;
    logic [3:0]  src;

    int nchecks = 0;
    int nerr = 0;
    bit mon_en = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_req_i(req),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_word_i(word),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_level_o(level), .irq_vec_o(vec), .irq_auto_o(autov), .irq_src_o(src)
    );

    // Behavioural reference state
    logic [15:0] m_mask, m_pend;
    logic [7:0]  m_ctrl [1:13];
    logic [7:0]  m_vec  [1:13];

    task automatic chk(input string tag, input int act, input int exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_rd(input int a);
        if (a >= 'h14 && a <= 'h20) return m_ctrl[a - 'h13];
        if (a >= 'h81 && a <= 'h8D) return m_vec[a - 'h80];
        case (a)
            'h36: return m_mask[15:8];
            'h37: return m_mask[7:0];
            'h3A: return m_pend[15:8];
            'h3B: return m_pend[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_wr(input int a, input logic [7:0] d);
        if (a >= 'h14 && a <= 'h20) m_ctrl[a - 'h13] = d;
        else if (a >= 'h81 && a <= 'h8D) m_vec[a - 'h80] = d;
        else if (a == 'h36) m_mask[15:8] = d;
        else if (a == 'h37) m_mask[7:0] = d;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mask = 16'hFFFF;
            m_pend = 16'h0000;
            for (int i = 1; i <= 13; i++) begin m_ctrl[i] = 8'h00; m_vec[i] = 8'h00; end
        end else begin
            m_pend = {2'b00, req, 1'b0};
            if (sel && wr) begin
                if (word) begin
                    m_wr(int'(addr) & ~1, wdata[15:8]);
                    m_wr(int'(addr) | 1,  wdata[7:0]);
                end else begin
                    m_wr(int'(addr), wdata[7:0]);
                end
            end
        end
    end

    // Expected outputs from the requirements
    task automatic expect_out(output int e_src, output int e_lvl, output int e_vec, output int e_auto);
        int best = 0;
        int w = 0;
        for (int i = 1; i <= 13; i++) begin
            if (m_pend[i] && !m_mask[i] && int'(m_ctrl[i][4:0]) > best) begin
                best = int'(m_ctrl[i][4:0]);
                w = i;
            end
        end
        e_src = 0; e_lvl = 0; e_vec = 0; e_auto = 0;
        if (w != 0 && m_ctrl[w][4:2] != 0) begin
            e_src = w;
            e_lvl = int'(m_ctrl[w][4:2]);
            e_auto = int'(m_ctrl[w][7]);
            e_vec = e_auto ? 24 + e_lvl : int'(m_vec[w]);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && mon_en) begin
            int es, el, ev, ea;
            expect_out(es, el, ev, ea);
            chk("R2 winner", int'(src), es);
            chk("R3 level", int'(level), el);
            if (el == 0)      chk("R4 vector", int'(vec), ev);
            else if (ea != 0) chk("R5 vector", int'(vec), ev);
            else              chk("R6 vector", int'(vec), ev);
            chk("R5 autovector flag", int'(autov), ea);
        end
    end

    task automatic bus_write(input int a, input bit w, input logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; word = w; addr = 9'(a); wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; word = 1'b0;
    endtask

    task automatic bus_read(input string tag, input int a, input bit w, input int exp);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; word = w; addr = 9'(a);
        #1;
        chk(tag, int'(rdata), exp);
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic set_req(input logic [13:1] r);
        @(negedge clk);
        req = r;
        @(negedge clk);
        #1;
    endtask

    task automatic out_is(input string tag, input int s, input int l, input int v, input int a);
        chk({tag, " src"}, int'(src), s);
        chk({tag, " level"}, int'(level), l);
        chk({tag, " vector"}, int'(vec), v);
        chk({tag, " auto"}, int'(autov), a);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchecks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1;

        // R8 reset state
        bus_read("R8 mask reset", 'h36, 1, 'hFFFF);
        bus_read("R8 pending reset", 'h3A, 1, 'h0000);
        bus_read("R8 control reset", 'h14, 0, 'h00);
        bus_read("R8 vector reset", 'h81, 0, 'h00);
        out_is("R8 idle", 0, 0, 0, 0);

        // R6/R3: source 1, level 3, priority 12, own vector
        bus_write('h14, 0, 16'h000C);
        bus_write('h81, 0, 16'h0040);
        bus_write('h36, 1, 16'hFFFD);
        set_req(13'b0_0000_0000_0001);
        out_is("R6 source1", 1, 3, 'h40, 0);

        // R1 and R9: masking takes effect right after the write edge
        bus_write('h36, 1, 16'hFFFF);
        #1; out_is("R1 R9 masked", 0, 0, 0, 0);
        bus_write('h36, 1, 16'hFFDD);
        #1; out_is("R9 unmasked", 1, 3, 'h40, 0);

        // R2 tie goes to lower source number
        bus_write('h18, 0, 16'h000C);
        bus_write('h85, 0, 16'h0055);
        set_req(13'b0_0000_0001_0001);
        out_is("R2 tie", 1, 3, 'h40, 0);
        bus_write('h36, 1, 16'hFFDF);
        #1; out_is("R2 after mask", 5, 3, 'h55, 0);

        // R5 autovector with higher sub-priority
        bus_write('h1C, 0, 16'h008D);
        bus_write('h36, 1, 16'hFDDD);
        set_req(13'b0_0001_0001_0001);
        out_is("R5 auto", 9, 3, 27, 1);
        bus_write('h14, 0, 16'h000E);
        #1; out_is("R2 subprio", 1, 3, 'h40, 0);

        // R4 winner at level 0
        bus_write('h14, 0, 16'h0003);
        bus_write('h18, 0, 16'h0002);
        bus_write('h1C, 0, 16'h0081);
        #1; out_is("R4 level zero", 0, 0, 0, 0);

        // R7 pending tracking, read-only
        bus_read("R7 pending", 'h3A, 1, 'h0222);
        set_req(13'b0_0000_0001_0001);
        bus_read("R7 pending drop", 'h3A, 1, 'h0022);
        bus_write('h3A, 1, 16'hFFFF);
        bus_read("R7 pending write ignored", 'h3A, 1, 'h0022);

        // R11 unmapped
        bus_write('h50, 0, 16'h00AB);
        bus_read("R11 unmapped read", 'h50, 0, 'h00);
        bus_read("R11 mask intact", 'h36, 1, 'hFDDD);

        // R10 lanes
        bus_write('h37, 0, 16'h0000);
        bus_write('h36, 0, 16'h0012);
        bus_read("R10 mask bytes", 'h36, 1, 'h1200);
        bus_write('h14, 1, 16'hA1B2);
        bus_read("R10 high lane", 'h14, 0, 'hA1);
        bus_read("R10 low lane", 'h15, 0, 'hB2);
        bus_read("R10 odd word", 'h15, 1, 'hA1B2);

        // Random mix, checked every cycle by the monitor
        for (int k = 0; k < 600; k++) begin
            int pick = $urandom_range(0, 9);
            int a;
            if (pick < 3) a = $urandom_range('h14, 'h20);
            else if (pick < 5) a = $urandom_range('h81, 'h8D);
            else if (pick < 7) a = 'h36 + $urandom_range(0, 1);
            else if (pick == 7) a = 'h3A;
            else a = $urandom_range('h40, 'h7F);
            if ($urandom_range(0, 2) == 0) begin
                @(negedge clk);
                req = 13'($urandom);
            end else begin
                bus_write(a, bit'($urandom_range(0, 1)), 16'($urandom));
            end
        end
        bus_read("R11 final unmapped", 'h41, 0, 'h00);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end
endmodule